// File: doc/BRIEF.md
# Keypad and Display I/O Controller

This block is a memory-mapped peripheral that sits on the bus of an 8-bit processor with a 16-bit address. It claims a single 256-byte page. Inside that page it holds three kinds of state. The first is a column-select register that drives the column lines of a 4×4 key matrix. The second is a read port that returns the matrix row lines after they pass through a synchroniser. The third is a bank of six latches, each holding the value shown on one position of a six-position display.

Firmware scans the keypad in a loop. It writes one column pattern, reads the rows back, and decodes the key. It updates a display position by writing a byte to that position's latch, and the latch keeps the byte until the next write to it. Any access outside the page, or to an offset inside the page that has no function, leaves every register unchanged and reads as zero.

Top module: `keypad_display_io`

## Requirements
- R1: An access takes effect only when address bits [15:8] equal 0xD0. A write to any other page changes no output, and a read from any other page returns 0x00.
- R2: A write to offset 0x00 of the page (address 0xD000) loads write-data bits [3:0] into the column register, which drives `colSel`. After reset the register holds 0.
- R3: A read from offset 0x01 (address 0xD001) returns the row lines in bits [3:0] and 0 in bits [7:4]. The rows pass through two flops, so a change on `rowIn` that is set up before a rising edge appears on this read after the second rising edge.
- R4: A write to offset 0x10+i (address 0xD010+i), for i from 0 to 5, stores the whole data byte in display latch i. Latch i drives `digitOut[8*i+7:8*i]`.
- R5: All six display latches reset to 0x00. A latch keeps its value until a write to its own address.
- R6: A read from offset 0x10+i returns the contents of display latch i.
- R7: A read from any offset in the page other than 0x01 and 0x10–0x15 returns 0x00. This includes offset 0x00, because the column register cannot be read back.
- R8: A write to offset 0x01, or to any offset other than 0x00 and 0x10–0x15, changes neither `colSel` nor any display latch.
- R9: `busRdData` is 0x00 in every cycle where `busRd` is low. A read changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Data from the processor |
| busWr | input | 1 | Write strobe, sampled on the rising edge |
| busRd | input | 1 | Read strobe; read data is combinational |
| busRdData | output | 8 | Data to the processor |
| colSel | output | 4 | Keypad column-select lines |
| rowIn | input | 4 | Keypad row lines, asynchronous |
| digitOut | output | 48 | Six display latches, latch i in bits [8i+7:8i] |

## Verification
The bench writes to every offset of the page with a distinct data pattern. A decoder that aliased a digit latch onto a nearby offset, or that answered a write to the row port, would move a latch or the column lines that the model leaves still. It repeats writes and reads across every other value of the high address byte, where a partial page compare would let data through. It sweeps all sixteen row patterns and samples after one edge and after two. A synchroniser with the wrong depth would show the new value early or late, and a read port that did not clear the upper bits would return a wrong high nibble.

// File: rtl/kdio_pkg.sv
package kdio_pkg;
  localparam int DIGIT_IDX_W = 4;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_ROWS  = 2'd1,
    RD_DIGIT = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic                   colWe;
    logic                   digitWe;
    logic [DIGIT_IDX_W-1:0] digitIdx;
    rdSrc_e                 rdSrc;
  } strobes_t;
endpackage

// File: rtl/kdio_ctrl.sv
module kdio_ctrl #(
  parameter int          ADDR_W     = 16,
  parameter int          NUM_DIGITS = 6,
  parameter logic [7:0]  PAGE_ID    = 8'hD0,
  parameter logic [7:0]  COL_OFF    = 8'h00,
  parameter logic [7:0]  ROW_OFF    = 8'h01,
  parameter logic [7:0]  DIGIT_BASE = 8'h10
) (
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  output kdio_pkg::strobes_t strobes
);
  import kdio_pkg::*;

  localparam logic [8:0] DIGIT_END = {1'b0, DIGIT_BASE} + 9'(NUM_DIGITS);

  logic       pageHit;
  logic [7:0] offset;
  logic       inDigit;
  logic [7:0] digitRel;

  assign pageHit  = (busAddr[ADDR_W-1:8] == PAGE_ID);
  assign offset   = busAddr[7:0];
  assign inDigit  = (offset >= DIGIT_BASE) && ({1'b0, offset} < DIGIT_END);
  assign digitRel = offset - DIGIT_BASE;

  always_comb begin
    strobes          = '0;
    strobes.rdSrc    = RD_NONE;
    strobes.digitIdx = digitRel[DIGIT_IDX_W-1:0];
    if (pageHit) begin
      strobes.colWe   = busWr && (offset == COL_OFF);
      strobes.digitWe = busWr && inDigit;
      if (busRd) begin
        if (offset == ROW_OFF)  strobes.rdSrc = RD_ROWS;
        else if (inDigit)       strobes.rdSrc = RD_DIGIT;
      end
    end
  end
endmodule

// File: rtl/kdio_datapath.sv
module kdio_datapath #(
  parameter int DATA_W      = 8,
  parameter int NUM_DIGITS  = 6,
  parameter int KEY_ROWS    = 4,
  parameter int KEY_COLS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  kdio_pkg::strobes_t           strobes,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic [KEY_ROWS-1:0]          rowIn,
  output logic [KEY_COLS-1:0]          colSel,
  output logic [NUM_DIGITS*DATA_W-1:0] digitFlat,
  output logic [DATA_W-1:0]            busRdData
);
  import kdio_pkg::*;

  logic [KEY_COLS-1:0] colReg;
  logic [DATA_W-1:0]   digitReg [NUM_DIGITS];
  logic [KEY_ROWS-1:0] syncQ    [SYNC_STAGES];
  logic [KEY_ROWS-1:0] rowSync;

  always_ff @(posedge clk) begin
    if (!rstN)              colReg <= '0;
    else if (strobes.colWe) colReg <= busWrData[KEY_COLS-1:0];
  end
  assign colSel = colReg;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDigit
    always_ff @(posedge clk) begin
      if (!rstN)
        digitReg[g] <= '0;
      else if (strobes.digitWe && (strobes.digitIdx == DIGIT_IDX_W'(g)))
        digitReg[g] <= busWrData;
    end
    assign digitFlat[g*DATA_W +: DATA_W] = digitReg[g];
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN)  syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= rowIn;
      else        syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end
  assign rowSync = syncQ[SYNC_STAGES-1];

  always_comb begin
    busRdData = '0;
    unique case (strobes.rdSrc)
      RD_ROWS:  busRdData = DATA_W'(rowSync);
      RD_DIGIT: begin
        for (int i = 0; i < NUM_DIGITS; i++)
          if (strobes.digitIdx == DIGIT_IDX_W'(i)) busRdData = digitReg[i];
      end
      default:  busRdData = '0;
    endcase
  end
endmodule

// File: rtl/keypad_display_io.sv
module keypad_display_io #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          NUM_DIGITS  = 6,
  parameter int          KEY_ROWS    = 4,
  parameter int          KEY_COLS    = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  PAGE_ID     = 8'hD0,
  parameter logic [7:0]  COL_OFF     = 8'h00,
  parameter logic [7:0]  ROW_OFF     = 8'h01,
  parameter logic [7:0]  DIGIT_BASE  = 8'h10
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic                         busWr,
  input  logic                         busRd,
  output logic [DATA_W-1:0]            busRdData,
  output logic [KEY_COLS-1:0]          colSel,
  input  logic [KEY_ROWS-1:0]          rowIn,
  output logic [NUM_DIGITS*DATA_W-1:0] digitOut
);
  kdio_pkg::strobes_t strobes;

  kdio_ctrl #(
    .ADDR_W(ADDR_W), .NUM_DIGITS(NUM_DIGITS), .PAGE_ID(PAGE_ID),
    .COL_OFF(COL_OFF), .ROW_OFF(ROW_OFF), .DIGIT_BASE(DIGIT_BASE)
  ) uCtrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strobes(strobes)
  );

  kdio_datapath #(
    .DATA_W(DATA_W), .NUM_DIGITS(NUM_DIGITS), .KEY_ROWS(KEY_ROWS),
    .KEY_COLS(KEY_COLS), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .rowIn(rowIn), .colSel(colSel), .digitFlat(digitOut),
    .busRdData(busRdData)
  );
endmodule

// File: rtl/kdio_checker.sv
module kdio_checker #(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter int          NUM_DIGITS = 6,
  parameter int          KEY_ROWS   = 4,
  parameter int          KEY_COLS   = 4,
  parameter logic [7:0]  PAGE_ID    = 8'hD0,
  parameter logic [7:0]  COL_OFF    = 8'h00,
  parameter logic [7:0]  ROW_OFF    = 8'h01,
  parameter logic [7:0]  DIGIT_BASE = 8'h10
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [ADDR_W-1:0]            busAddr,
  input logic [DATA_W-1:0]            busWrData,
  input logic                         busWr,
  input logic                         busRd,
  input logic [DATA_W-1:0]            busRdData,
  input logic [KEY_COLS-1:0]          colSel,
  input logic [KEY_ROWS-1:0]          rowIn,
  input logic [NUM_DIGITS*DATA_W-1:0] digitOut
);
  localparam logic [ADDR_W-1:0] COL_ADDR = {PAGE_ID, COL_OFF};
  localparam logic [ADDR_W-1:0] ROW_ADDR = {PAGE_ID, ROW_OFF};

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R2: column register load and hold
  a_r2_col_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == COL_ADDR) |=> (colSel == $past(busWrData[KEY_COLS-1:0])));
  a_r2_col_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == COL_ADDR) |=> $stable(colSel));

  // R9: idle read bus
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdData == '0));

  // R1: off-page reads return zero
  a_r1_off_page_read: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[ADDR_W-1:8] != PAGE_ID) |-> (busRdData == '0));

  // R3: two-edge row latency and cleared upper bits
  a_r3_row_latency: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ROW_ADDR && sinceRst >= 2'd2)
      |-> (busRdData == DATA_W'($past(rowIn, 2))));

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : gDig
    localparam logic [ADDR_W-1:0] DIG_ADDR = {PAGE_ID, 8'(DIGIT_BASE + g)};
    // R4: latch load
    a_r4_digit_load: assert property (@(posedge clk) disable iff (!rstN)
      (busWr && busAddr == DIG_ADDR) |=> (digitOut[g*DATA_W +: DATA_W] == $past(busWrData)));
    // R5: latch hold
    a_r5_digit_hold: assert property (@(posedge clk) disable iff (!rstN)
      !(busWr && busAddr == DIG_ADDR) |=> $stable(digitOut[g*DATA_W +: DATA_W]));
    // R6: latch readback
    a_r6_digit_read: assert property (@(posedge clk) disable iff (!rstN)
      (busRd && busAddr == DIG_ADDR) |-> (busRdData == digitOut[g*DATA_W +: DATA_W]));
  end
endmodule

bind keypad_display_io kdio_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_DIGITS(NUM_DIGITS),
  .KEY_ROWS(KEY_ROWS), .KEY_COLS(KEY_COLS), .PAGE_ID(PAGE_ID),
  .COL_OFF(COL_OFF), .ROW_OFF(ROW_OFF), .DIGIT_BASE(DIGIT_BASE)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .colSel(colSel),
  .rowIn(rowIn), .digitOut(digitOut)
);

// File: tb/tb_keypad_display_io.sv
module tb_keypad_display_io;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [3:0]  colSel;
  logic [3:0]  rowIn = '0;
  logic [47:0] digitOut;

  int checks = 0;
  int errors = 0;
  logic [3:0] expCol;
  logic [7:0] expDig [ND];
  logic [3:0] rowModel;

  keypad_display_io dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData), .colSel(colSel),
    .rowIn(rowIn), .digitOut(digitOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check({req, " col"}, 64'(colSel), 64'(expCol));
    for (int i = 0; i < ND; i++)
      check({req, " digit"}, 64'(digitOut[i*8 +: 8]), 64'(expDig[i]));
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (a[15:8] == 8'hD0) begin
      if (a[7:0] == 8'h00) expCol = d[3:0];
      else if (a[7:0] >= 8'h10 && a[7:0] < 8'h16) expDig[a[7:0] - 8'h10] = d;
    end
  endtask

  function automatic logic [7:0] expRead(input logic [15:0] a);
    if (a[15:8] != 8'hD0) return 8'h00;
    if (a[7:0] == 8'h01) return {4'h0, rowModel};
    if (a[7:0] >= 8'h10 && a[7:0] < 8'h16) return expDig[a[7:0] - 8'h10];
    return 8'h00;
  endfunction

  task automatic busReadCheck(input string req, input logic [15:0] a);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1;
    check(req, 64'(busRdData), 64'(expRead(a)));
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    expCol = '0;
    for (int i = 0; i < ND; i++) expDig[i] = '0;
    rowModel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 R5: reset state
    checkState("R2/R5 reset");
    busReadCheck("R3 reset rows", 16'hD001);
    // R9: idle bus reads zero
    #1 check("R9 idle", 64'(busRdData), 64'h0);

    // R2: every column value, upper bits set to show they do not leak
    for (int v = 0; v < 16; v++) begin
      busWrite(16'hD000, 8'(v) | 8'hF0);
      checkState("R2 col sweep");
    end

    // R4 R5: each latch in turn, others must hold
    for (int i = 0; i < ND; i++) begin
      busWrite(16'hD010 + 16'(i), 8'h31 + 8'(i * 17));
      checkState("R4/R5 digit write");
    end

    // R8 R4 R2: write to every offset in the page
    for (int lo = 0; lo < 256; lo++) begin
      busWrite({8'hD0, 8'(lo)}, 8'(lo) ^ 8'hA5);
      checkState("R8 page write sweep");
    end

    // R6 R7: read every offset in the page
    rowIn = 4'hB;
    repeat (2) @(posedge clk);
    rowModel = 4'hB;
    for (int lo = 0; lo < 256; lo++)
      busReadCheck("R6/R7 page read sweep", {8'hD0, 8'(lo)});

    // R1: other pages ignore writes and read as zero
    for (int hi = 0; hi < 256; hi++) begin
      if (hi != 8'hD0) begin
        busWrite({8'(hi), 8'h00}, 8'(hi) ^ 8'h5A);
        busWrite({8'(hi), 8'h12}, 8'(hi) ^ 8'h3C);
        checkState("R1 off-page write");
        busReadCheck("R1 off-page row read", {8'(hi), 8'h01});
        busReadCheck("R1 off-page digit read", {8'(hi), 8'h10});
      end
    end

    // R3: every row pattern; old value after one edge, new after two
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      rowIn = 4'(r);
      busAddr = 16'hD001; busRd = 1'b1;
      @(negedge clk);
      check("R3 one edge old rows", 64'(busRdData), 64'({4'h0, rowModel}));
      @(negedge clk);
      rowModel = 4'(r);
      check("R3 two edges new rows", 64'(busRdData), 64'({4'h0, rowModel}));
      busRd = 1'b0;
      // R9: a read changes nothing
      checkState("R9 read side effect");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule